// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM array refreshed from a free-running system clock. An interval timer adds one owed refresh every refresh period, which is about 15.6 µs for 2,048 rows refreshed every 32 ms. A backlog counter holds the owed refreshes, and the block requests the memory bus from the access sequencer whenever that counter is non-zero. Once the sequencer grants the bus, the block drives the row and column strobes through one refresh cycle. It then pulses a completion flag and retires one owed refresh.

Three kinds of cycle are supported. The first is a strobe-order refresh: the column strobe falls before the row strobe, and no address is driven. The second is a row-address refresh: an internal row counter is presented while the row strobe is low, and the column strobe stays high. The third is hidden refresh, used when a read is holding the column strobe low at grant time: the column strobe stays low through precharge and the row strobe is cycled again.

Up to eight refreshes may be postponed while the bus is busy. When the backlog is full, an urgent flag tells the access sequencer to hold off new accesses. All timings are parameters in nanoseconds and are converted to clock cycles with the clock period.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, owed is 0, ref_req, ref_urgent, ref_done and row_addr_oe are 0, and ras_n and cas_n are 1. owed increases by one on every REFI_CYC-th clock edge after reset is released.
- R2: ref_req rises one cycle after owed becomes non-zero while no refresh is running. It then stays high until a cycle in which ref_grant is 1.
- R3: owed never exceeds BACKLOG (8) and does not grow past it. ref_urgent is 1 exactly when owed equals BACKLOG.
- R4: When a new interval and the completion of a refresh land on the same clock edge, owed is left unchanged.
- R5: With ras_only_mode=0 and no hidden refresh, cas_n falls TCSR_CYC cycles before ras_n falls, and row_addr_oe stays 0.
- R6: With ras_only_mode=1 at grant, cas_n stays 1 throughout, and row_addr_oe is 1 with row_addr equal to the row counter while ras_n is low. The mode is captured on the grant cycle; later changes to the input have no effect on that refresh.
- R7: The row counter starts at 0 after reset. It advances by one only on completion of a row-address refresh, and wraps from 2047 to 0.
- R8: ras_n stays high for TRP_CYC cycles after the grant edge before the refresh sequence starts. ref_done is a single-cycle pulse, raised TRP_CYC cycles after ras_n returns high.
- R9: With hidden_en=1 and read_hold=1 at grant, cas_n is 0 from the grant edge, and ras_n falls TRP_CYC cycles later. With read_hold=0, an ordinary strobe-order refresh runs instead.
- R10: ras_n stays low for exactly TRAS_CYC cycles in every refresh.

Timing as a function of G, the clock edge that samples ref_grant:

| Refresh kind | ras_n falls at edge | ref_done is high at edge |
| --- | --- | --- |
| Strobe-order | G+TRP+TCSR | G+2·TRP+TRAS+TCSR |
| Row-address or hidden | G+TRP | G+2·TRP+TRAS |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode | input | 1 | 1 selects row-address refresh, 0 selects strobe-order refresh |
| hidden_en | input | 1 | Allows hidden refresh chained onto a read |
| read_hold | input | 1 | The access sequencer is holding the column strobe low after a read |
| ref_grant | input | 1 | Bus granted to the refresh sequence |
| ref_req | output | 1 | Refresh bus request |
| ref_urgent | output | 1 | Backlog full; new accesses must wait |
| owed | output | PEND_W | Number of outstanding refreshes |
| ras_n | output | 1 | Row strobe drive during refresh, active low |
| cas_n | output | 1 | Column strobe drive during refresh, active low |
| row_addr | output | ROW_W | Row address for row-address refresh, 0 when not driven |
| row_addr_oe | output | 1 | Row address drive enable |
| ref_done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same clock edge: a new refresh interval expiring, and a finished refresh retiring from the backlog. The bench provokes this by delaying its grant until the cycle count modulo the interval makes the decrement edge land on the tick edge. At that edge it checks that owed reads the same before and after. A cycle-level model of owed runs on every edge, so every other coincidence met while draining a full backlog is judged as well.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_SETUP,
    ST_ACT,
    ST_REC,
    ST_DONE
  } ref_state_t;

  // Round a time in ns up to whole clock cycles of period ps.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned ps);
    return (ns * 1000 + ps - 1) / ps;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned REFI_CYC = 1954
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = $clog2(REFI_CYC);
  localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R1: the interval counter never leaves its range
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);

endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int unsigned BACKLOG = 8,
  localparam int unsigned PW = $clog2(BACKLOG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] owed,
  output logic          full
);
  localparam logic [PW-1:0] LIMIT = PW'(BACKLOG);

  assign full = (owed == LIMIT);

  always_ff @(posedge clk) begin
    if (rst) owed <= '0;
    else if (inc && !dec && !full) owed <= owed + 1'b1;
    else if (dec && !inc)          owed <= owed - 1'b1;
  end

  assert_backlog_bound_R3: assert property (@(posedge clk) disable iff (rst) owed <= LIMIT);
  assert_tie_hold_R4: assert property (@(posedge clk) disable iff (rst) (inc && dec) |=> $stable(owed));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst) dec |-> (owed != '0));

endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int unsigned ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  // Natural binary wrap takes the last row back to 0.
  always_ff @(posedge clk) begin
    if (rst)      row <= '0;
    else if (adv) row <= row + 1'b1;
  end

  assert_row_hold_R7: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(row));

endmodule

// File: rtl/ref_seq.sv
module ref_seq import dram_ref_pkg::*; #(
  parameter int unsigned TRP_CYC  = 5,
  parameter int unsigned TRAS_CYC = 8,
  parameter int unsigned TCSR_CYC = 2,
  parameter int unsigned ROW_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             owed_nz,
  input  logic             grant,
  input  logic             ras_only,
  input  logic             hidden_en,
  input  logic             read_hold,
  input  logic [ROW_W-1:0] row,
  output logic             req,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr,
  output logic             addr_oe,
  output logic             done,
  output logic             adv
);
  localparam int unsigned MAXC = (TRAS_CYC > TRP_CYC) ?
                                 ((TRAS_CYC > TCSR_CYC) ? TRAS_CYC : TCSR_CYC) :
                                 ((TRP_CYC > TCSR_CYC) ? TRP_CYC : TCSR_CYC);
  localparam int unsigned TW = $clog2(MAXC + 1);
  localparam logic [TW-1:0] LD_RP  = TW'(TRP_CYC - 1);
  localparam logic [TW-1:0] LD_RAS = TW'(TRAS_CYC - 1);
  localparam logic [TW-1:0] LD_CSR = TW'(TCSR_CYC - 1);

  ref_state_t    state, state_d;
  logic [TW-1:0] tmr, tmr_d;
  logic          rom_q, hid_q, rom_d, hid_d, take;

  assign take  = (state == ST_WAIT) && grant;
  assign hid_d = take ? (hidden_en && read_hold) : hid_q;
  assign rom_d = take ? (ras_only && !(hidden_en && read_hold)) : rom_q;

  always_comb begin
    state_d = state;
    tmr_d   = (tmr != '0) ? tmr - 1'b1 : tmr;
    unique case (state)
      ST_IDLE: if (owed_nz) state_d = ST_WAIT;
      ST_WAIT: if (grant) begin state_d = ST_PRE; tmr_d = LD_RP; end
      ST_PRE: if (tmr == '0) begin
        if (!rom_q && !hid_q) begin state_d = ST_SETUP; tmr_d = LD_CSR; end
        else                  begin state_d = ST_ACT;   tmr_d = LD_RAS; end
      end
      ST_SETUP: if (tmr == '0) begin state_d = ST_ACT; tmr_d = LD_RAS; end
      ST_ACT:   if (tmr == '0) begin state_d = ST_REC; tmr_d = LD_RP;  end
      ST_REC:   if (tmr == '0) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      rom_q   <= 1'b0;
      hid_q   <= 1'b0;
      req     <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      addr    <= '0;
      addr_oe <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= state_d;
      tmr     <= tmr_d;
      rom_q   <= rom_d;
      hid_q   <= hid_d;
      req     <= (state_d == ST_WAIT);
      ras_n   <= (state_d != ST_ACT);
      cas_n   <= !((state_d == ST_SETUP) || (state_d == ST_ACT && !rom_d) ||
                   (state_d == ST_PRE && hid_d));
      addr_oe <= rom_d && (state_d == ST_PRE || state_d == ST_ACT);
      addr    <= (rom_d && (state_d == ST_PRE || state_d == ST_ACT)) ? row : '0;
      done    <= (state_d == ST_DONE);
    end
  end

  assign adv = done && rom_q;

  assert_cbr_order_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !rom_q) |-> (!cas_n && $past(!cas_n)));
  assert_ras_only_cas_high_R6: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && rom_q) |-> (cas_n && addr_oe));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  assert_done_after_high_R8: assert property (@(posedge clk) disable iff (rst) done |-> ras_n);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched import dram_ref_pkg::*; #(
  parameter int unsigned CLK_PS   = 8000,
  parameter int unsigned REFI_NS  = 15625,
  parameter int unsigned TRP_NS   = 40,
  parameter int unsigned TRAS_NS  = 64,
  parameter int unsigned TCSR_NS  = 10,
  parameter int unsigned ROW_W    = 11,
  parameter int unsigned BACKLOG  = 8,
  localparam int unsigned PEND_W  = $clog2(BACKLOG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_only_mode,
  input  logic              hidden_en,
  input  logic              read_hold,
  input  logic              ref_grant,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic [PEND_W-1:0] owed,
  output logic              ras_n,
  output logic              cas_n,
  output logic [ROW_W-1:0]  row_addr,
  output logic              row_addr_oe,
  output logic              ref_done
);
  localparam int unsigned REFI_CYC = ns_to_cyc(REFI_NS, CLK_PS);
  localparam int unsigned TRP_CYC  = ns_to_cyc(TRP_NS, CLK_PS);
  localparam int unsigned TRAS_CYC = ns_to_cyc(TRAS_NS, CLK_PS);
  localparam int unsigned TCSR_CYC = ns_to_cyc(TCSR_NS, CLK_PS);

  logic             tick, adv;
  logic [ROW_W-1:0] row;

  ref_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst(rst), .tick(tick)
  );

  ref_backlog #(.BACKLOG(BACKLOG)) u_backlog (
    .clk(clk), .rst(rst), .inc(tick), .dec(ref_done), .owed(owed), .full(ref_urgent)
  );

  ref_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .adv(adv), .row(row)
  );

  ref_seq #(
    .TRP_CYC(TRP_CYC), .TRAS_CYC(TRAS_CYC), .TCSR_CYC(TCSR_CYC), .ROW_W(ROW_W)
  ) u_seq (
    .clk(clk), .rst(rst), .owed_nz(owed != '0), .grant(ref_grant),
    .ras_only(ras_only_mode), .hidden_en(hidden_en), .read_hold(read_hold), .row(row),
    .req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .addr(row_addr), .addr_oe(row_addr_oe),
    .done(ref_done), .adv(adv)
  );

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_grant) |=> ref_req);
  assert_no_req_when_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (owed == '0) |-> !ref_req);

endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int REFI = 25;
  localparam int TRP  = 5;
  localparam int TRAS = 8;
  localparam int TCSR = 2;

  typedef struct {
    int g; int fall_off; int done_off; bit cas_low; int lead; bit oe; int addr;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic ras_only_mode = 1'b0, hidden_en = 1'b0, read_hold = 1'b0, ref_grant = 1'b0;
  logic ref_req, ref_urgent, ras_n, cas_n, row_addr_oe, ref_done;
  logic [3:0]  owed;
  logic [10:0] row_addr;

  dram_refresh_sched #(
    .CLK_PS(8000), .REFI_NS(200), .TRP_NS(40), .TRAS_NS(64), .TCSR_NS(16),
    .ROW_W(11), .BACKLOG(8)
  ) i_dram_refresh_sched (
    .clk(clk), .rst(rst), .ras_only_mode(ras_only_mode), .hidden_en(hidden_en),
    .read_hold(read_hold), .ref_grant(ref_grant), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .owed(owed), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr),
    .row_addr_oe(row_addr_oe), .ref_done(ref_done)
  );

  always #4 clk = ~clk;

  int n = 0, m_owed = 0, total = 0, fails = 0, exp_row = 0;
  bit done_s = 1'b0, prev_ras = 1'b1, prev_cas = 1'b1, prev_done = 1'b0;
  int cas_fall = 0, ras_low_at = 0;
  item_t q[$];
  item_t cur;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", rq, act, exp, n);
    end
  endtask

  // Model of owed from R1, R3 and R4
  always @(posedge clk) begin
    if (rst) begin n = 0; m_owed = 0; end
    else begin
      bit inc;
      n++;
      inc = (n % REFI == 0);
      if (inc && !done_s && m_owed < 8) m_owed++;
      else if (done_s && !inc) m_owed--;
    end
  end

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      check(owed == 4'(m_owed), "R1 owed model", owed, m_owed);
      check(ref_urgent == (m_owed == 8), "R3 urgent", ref_urgent, m_owed == 8);
      if (prev_cas && !cas_n) cas_fall = n;
      if (prev_ras && !ras_n) begin
        if (q.size() == 0) check(1'b0, "R8 unexpected ras fall", 0, 1);
        else begin
          cur = q.pop_front();
          check(n - cur.g == cur.fall_off, "R8 ras fall offset", n - cur.g, cur.fall_off);
          check(cas_n == !cur.cas_low, "R5 R6 R9 cas at ras fall", cas_n, !cur.cas_low);
          if (cur.lead >= 0) check(n - cas_fall == cur.lead, "R5 R9 cas lead", n - cas_fall, cur.lead);
          check(row_addr_oe == cur.oe, "R6 addr oe", row_addr_oe, cur.oe);
          check(int'(row_addr) == cur.addr, "R6 R7 row addr", row_addr, cur.addr);
        end
        ras_low_at = n;
      end
      if (!prev_ras && ras_n) check(n - ras_low_at == TRAS, "R10 ras low", n - ras_low_at, TRAS);
      if (ref_done && !prev_done) check(n - cur.g == cur.done_off, "R8 done offset", n - cur.g, cur.done_off);
      if (ref_done && prev_done) check(1'b0, "R8 done width", 2, 1);
    end
    prev_ras = ras_n; prev_cas = cas_n; prev_done = ref_done; done_s = ref_done;
  end

  // kind: 0 strobe-order, 1 row-address, 2 hidden, 3 hidden enabled without read hold
  task automatic refresh(input int kind, input bit sync);
    item_t it;
    int ob;
    do @(negedge clk); while (!(ref_req && (!sync || (n % REFI) == 3)));
    ras_only_mode = (kind == 1);
    hidden_en = (kind >= 2);
    read_hold = (kind == 2);
    ref_grant = 1'b1;
    it.g = n + 1;
    it.cas_low = (kind != 1);
    it.oe = (kind == 1);
    it.addr = (kind == 1) ? exp_row : 0;
    it.fall_off = (kind == 0 || kind == 3) ? TRP + TCSR : TRP;
    it.done_off = it.fall_off + TRAS + TRP;
    it.lead = (kind == 1) ? -1 : ((kind == 2) ? TRP : TCSR);
    q.push_back(it);
    @(negedge clk);
    ref_grant = 1'b0;
    ras_only_mode = (kind != 1);   // R6: captured at grant, flip must not matter
    read_hold = 1'b0;
    if (kind == 1) exp_row = (exp_row + 1) % 2048;
    do @(negedge clk); while (!ref_done);
    ob = owed;
    @(negedge clk);
    if (sync) begin
      check((n % REFI) == 0, "R4 alignment", n % REFI, 0);
      check(int'(owed) == ob, "R4 tie owed unchanged", owed, ob);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(owed == 0 && !ref_req && !ref_urgent && !ref_done && !row_addr_oe,
          "R1 reset outputs", {owed, ref_req, ref_urgent, ref_done, row_addr_oe}, 0);
    check(ras_n && cas_n, "R1 reset strobes", {ras_n, cas_n}, 3);
    do @(negedge clk); while (owed == 0);
    check(n == REFI, "R1 first interval", n, REFI);
    @(negedge clk);
    check(ref_req && n == REFI + 1, "R2 req rise", ref_req, 1);
    repeat (3) @(negedge clk);
    check(ref_req, "R2 req held without grant", ref_req, 1);
    refresh(0, 1'b0);
    refresh(1, 1'b0);
    refresh(1, 1'b0);
    refresh(2, 1'b0);
    refresh(3, 1'b0);
    refresh(0, 1'b1);
    repeat (10 * REFI) @(negedge clk);
    check(owed == 8, "R3 saturate", owed, 8);
    check(ref_urgent, "R3 urgent at full", ref_urgent, 1);
    refresh(0, 1'b0);
    check(!ref_urgent, "R3 urgent clears", ref_urgent, 0);
    refresh(1, 1'b0);
    check(exp_row == 3, "R7 rows after strobe-order refreshes", exp_row, 3);
    for (int k = 0; k < 2045; k++) refresh(1, 1'b0);
    check(exp_row == 0, "R7 wrap model", exp_row, 0);
    refresh(1, 1'b0);   // scoreboard expects row 0 here
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule